// File: doc/BRIEF.md
# Double-Buffered Tile Loop Sequencer

This controller walks the tile grid of a blocked matrix product and issues the commands that keep a compute array busy while data moves. The grid has three dimensions: row tiles, depth tiles and column tiles. It steps through them in tile-sized strides. For every column tile it first asks the data mover to fetch the following tile into the spare scratchpad bank. It then asks the array to load the weight tile and run on the bank that already holds data. A tile retires only when both the run and the overlapped fetch have finished. The banks then trade roles, so a steady-state tile costs the longer of the two latencies and not their sum.

Each new (row, depth) pair starts with a prologue. That prologue fetches column tile zero into bank 0 and waits for the fetch before any compute begins. The last column tile of a pair has no fetch to overlap. The controller also counts the cycles in which compute has finished but the overlapped fetch has not. This gives a direct measure of how well the fetch is hidden.

Top module: `tile_pipe_seq`

## Requirements
- R1: In idle, a `start` pulse with all three sizes nonzero samples `dim_m`, `dim_n`, `dim_k`, and `busy` is high from the next cycle. While `busy` is high, `start` and the size inputs are ignored.
- R2: Compute tiles are visited with the row index outermost, then depth, then column innermost, each advancing by P (default 16). Every `acc_start` presents the current row, column and depth indices.
- R3: For each (row, depth) pair, the first command is a fetch of column tile 0 into bank 0. No `wgt_load` follows until `dma_done` has been seen high after that fetch.
- R4: For a column tile with col+P < N, one `dma_start` for column col+P of the same row, into the bank opposite to the compute bank, is issued before that tile's `wgt_load`.
- R5: For the last column tile of a pair (col+P >= N), no fetch is issued between its start and its retirement.
- R6: Each `wgt_load` carries the column and depth of the tile and occurs exactly one cycle before that tile's `acc_start`.
- R7: A tile retires only after `acc_done` and then `dma_done` are high. The compute bank toggles at retirement. A fetch or run is never started while its engine reports busy.
- R8: `stall_cycles` clears on an accepted start and increments once per cycle in which compute has finished while an overlapped fetch is still running.
- R9: `done` is a one-cycle pulse in the first cycle after the last tile retires, with `busy` low in that cycle.
- R10: A `start` with any size equal to zero issues no command, never raises `busy`, and pulses `done` in the following cycle.
- R11: Both engines take a one-cycle start pulse and return a done level. That level must fall at the clock edge that samples the pulse and rise when the work ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Job start pulse |
| dim_m | input | DIM_W | Row extent, multiple of P |
| dim_n | input | DIM_W | Column extent, multiple of P |
| dim_k | input | DIM_W | Depth extent, multiple of P |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle job completion pulse |
| dma_start | output | 1 | Fetch command pulse |
| dma_bank | output | 1 | Destination bank of the fetch |
| dma_row | output | DIM_W | Row index of the fetched tile |
| dma_col | output | DIM_W | Column index of the fetched tile |
| dma_done | input | 1 | Data mover idle level |
| wgt_load | output | 1 | Weight-load command pulse |
| wgt_col | output | DIM_W | Column index of the weight tile |
| wgt_depth | output | DIM_W | Depth index of the weight tile |
| acc_start | output | 1 | Compute run pulse |
| acc_bank | output | 1 | Bank the array reads |
| acc_row | output | DIM_W | Row index of the compute tile |
| acc_col | output | DIM_W | Column index of the compute tile |
| acc_depth | output | DIM_W | Depth index of the compute tile |
| acc_done | input | 1 | Array idle level |
| stall_cycles | output | CNT_W | Cycles spent waiting on a fetch after compute ended |

## Verification
The two events that can meet in one cycle are the end of compute and the end of the overlapped fetch. The controller must move into its fetch-wait step just as the fetch reports idle. The bench provokes this by setting the fetch latency exactly three cycles longer than the compute latency, and then one cycle longer than that. It judges the case by the stall count, zero in the first setting and one per overlapped tile in the second, and by an unchanged command order. Every command pulse is also logged and compared against an order built from nested loops.

// File: rtl/tile_pipe_pkg.sv
package tile_pipe_pkg;
  // loop slots inside the index nest, innermost first
  localparam int LOOP_N = 0;
  localparam int LOOP_K = 1;
  localparam int LOOP_M = 2;
  localparam int NUM_LOOPS = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRO_DMA,
    ST_PRO_WAIT,
    ST_ISSUE,
    ST_WGT,
    ST_RUN,
    ST_ACC_WAIT,
    ST_DMA_WAIT,
    ST_FIN
  } seq_state_e;
endpackage

// File: rtl/tile_loop_idx.sv
module tile_loop_idx #(
  parameter int DIM_W = 16,
  parameter int P     = 16,
  parameter int LOOPS = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr,
  input  logic                        adv,
  input  logic [LOOPS-1:0][DIM_W-1:0] lim,
  output logic [LOOPS-1:0][DIM_W-1:0] idx,
  output logic [LOOPS-1:0]            last
);
  localparam int ALIGN = $clog2(P);

  logic [LOOPS:0] carry;
  assign carry[0] = adv;

  for (genvar d = 0; d < LOOPS; d++) begin : g_loop
    logic [DIM_W:0] nxt;
    assign nxt        = {1'b0, idx[d]} + (DIM_W+1)'(P);
    assign last[d]    = nxt >= {1'b0, lim[d]};
    assign carry[d+1] = carry[d] & last[d];

    always_ff @(posedge clk) begin
      if (rst || clr)
        idx[d] <= '0;
      else if (carry[d])
        idx[d] <= last[d] ? '0 : nxt[DIM_W-1:0];
    end

    // R2
    idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
      (lim[d] != '0) |-> (idx[d] < lim[d] && idx[d][ALIGN-1:0] == '0));
  end
endmodule

// File: rtl/tile_stall_cnt.sv
module tile_stall_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (en && cnt != TOP)
      cnt <= cnt + 1'b1;
  end

  // R8
  stall_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && cnt != TOP) |=> cnt == $past(cnt) + 1'b1);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(cnt));
endmodule

// File: rtl/tile_seq_fsm.sv
module tile_seq_fsm
  import tile_pipe_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic dim_zero,
  input  logic dma_done,
  input  logic acc_done,
  input  logic last_n,
  input  logic last_k,
  input  logic last_m,
  output logic accept,
  output logic adv,
  output logic dma_start,
  output logic dma_ahead,
  output logic dma_bank,
  output logic wgt_load,
  output logic acc_start,
  output logic cur_bank,
  output logic busy,
  output logic done,
  output logic stall_en
);
  seq_state_e st, st_nx;
  logic       bank_q, bank_nx;

  always_comb begin
    st_nx   = st;
    bank_nx = bank_q;
    case (st)
      ST_IDLE:     if (start) begin
                     st_nx   = dim_zero ? ST_FIN : ST_PRO_DMA;
                     bank_nx = 1'b0;
                   end
      ST_PRO_DMA:  st_nx = ST_PRO_WAIT;
      ST_PRO_WAIT: if (dma_done) st_nx = ST_ISSUE;
      ST_ISSUE:    st_nx = ST_WGT;
      ST_WGT:      st_nx = ST_RUN;
      ST_RUN:      st_nx = ST_ACC_WAIT;
      ST_ACC_WAIT: if (acc_done) st_nx = ST_DMA_WAIT;
      ST_DMA_WAIT: if (dma_done) begin
                     bank_nx = ~bank_q;
                     if (!last_n)
                       st_nx = ST_ISSUE;
                     else if (!(last_k && last_m)) begin
                       st_nx   = ST_PRO_DMA;
                       bank_nx = 1'b0;
                     end else
                       st_nx = ST_FIN;
                   end
      ST_FIN:      st_nx = ST_IDLE;
      default:     st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      bank_q <= 1'b0;
    end else begin
      st     <= st_nx;
      bank_q <= bank_nx;
    end
  end

  assign accept    = (st == ST_IDLE) && start;
  assign adv       = (st == ST_DMA_WAIT) && dma_done;
  assign dma_ahead = (st == ST_ISSUE);
  assign dma_start = (st == ST_PRO_DMA) || (dma_ahead && !last_n);
  assign dma_bank  = dma_ahead ? ~bank_q : bank_q;
  assign wgt_load  = (st == ST_WGT);
  assign acc_start = (st == ST_RUN);
  assign cur_bank  = bank_q;
  assign busy      = (st != ST_IDLE) && (st != ST_FIN);
  assign done      = (st == ST_FIN);
  assign stall_en  = (st == ST_DMA_WAIT) && !dma_done;

  // R6
  wgt_before_run_chk: assert property (@(posedge clk) disable iff (rst)
    acc_start |-> $past(wgt_load));
  // R7
  advance_gate_chk: assert property (@(posedge clk) disable iff (rst)
    adv |-> (dma_done && acc_done));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
endmodule

// File: rtl/tile_pipe_seq.sv
module tile_pipe_seq
  import tile_pipe_pkg::*;
#(
  parameter int DIM_W = 16,
  parameter int P     = 16,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DIM_W-1:0] dim_m,
  input  logic [DIM_W-1:0] dim_n,
  input  logic [DIM_W-1:0] dim_k,
  output logic             busy,
  output logic             done,
  output logic             dma_start,
  output logic             dma_bank,
  output logic [DIM_W-1:0] dma_row,
  output logic [DIM_W-1:0] dma_col,
  input  logic             dma_done,
  output logic             wgt_load,
  output logic [DIM_W-1:0] wgt_col,
  output logic [DIM_W-1:0] wgt_depth,
  output logic             acc_start,
  output logic             acc_bank,
  output logic [DIM_W-1:0] acc_row,
  output logic [DIM_W-1:0] acc_col,
  output logic [DIM_W-1:0] acc_depth,
  input  logic             acc_done,
  output logic [CNT_W-1:0] stall_cycles
);
  logic [NUM_LOOPS-1:0][DIM_W-1:0] lim_q, idx;
  logic [NUM_LOOPS-1:0]            last;
  logic accept, adv, dma_ahead, stall_en, dim_zero;

  assign dim_zero = (dim_m == '0) || (dim_n == '0) || (dim_k == '0);

  always_ff @(posedge clk) begin
    if (rst)
      lim_q <= '0;
    else if (accept) begin
      lim_q[LOOP_N] <= dim_n;
      lim_q[LOOP_K] <= dim_k;
      lim_q[LOOP_M] <= dim_m;
    end
  end

  tile_loop_idx #(.DIM_W(DIM_W), .P(P), .LOOPS(NUM_LOOPS)) u_idx (
    .clk(clk), .rst(rst), .clr(accept), .adv(adv),
    .lim(lim_q), .idx(idx), .last(last)
  );

  tile_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .dim_zero(dim_zero),
    .dma_done(dma_done), .acc_done(acc_done),
    .last_n(last[LOOP_N]), .last_k(last[LOOP_K]), .last_m(last[LOOP_M]),
    .accept(accept), .adv(adv), .dma_start(dma_start), .dma_ahead(dma_ahead),
    .dma_bank(dma_bank), .wgt_load(wgt_load), .acc_start(acc_start),
    .cur_bank(acc_bank), .busy(busy), .done(done), .stall_en(stall_en)
  );

  tile_stall_cnt #(.CNT_W(CNT_W)) u_stall (
    .clk(clk), .rst(rst), .clr(accept), .en(stall_en), .cnt(stall_cycles)
  );

  assign dma_row   = idx[LOOP_M];
  assign dma_col   = dma_ahead ? idx[LOOP_N] + DIM_W'(P) : idx[LOOP_N];
  assign wgt_col   = idx[LOOP_N];
  assign wgt_depth = idx[LOOP_K];
  assign acc_row   = idx[LOOP_M];
  assign acc_col   = idx[LOOP_N];
  assign acc_depth = idx[LOOP_K];

  // R4
  ahead_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_start && dma_ahead) |-> (dma_bank != acc_bank));
  // R7
  engine_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_start |-> dma_done) and (acc_start |-> acc_done));
endmodule

// File: tb/test_tile_pipe_seq.sv
module test_tile_pipe_seq;
  localparam int DW = 16;
  localparam int P  = 16;
  localparam int CW = 32;

  logic clk = 0, rst = 1, start = 0;
  logic [DW-1:0] dim_m = 0, dim_n = 0, dim_k = 0;
  logic busy, done, dma_start, dma_bank, wgt_load, acc_start, acc_bank;
  logic [DW-1:0] dma_row, dma_col, wgt_col, wgt_depth, acc_row, acc_col, acc_depth;
  logic dma_done = 1, acc_done = 1;
  logic [CW-1:0] stall_cycles;

  always #2.5 clk = ~clk;

  tile_pipe_seq #(.DIM_W(DW), .P(P), .CNT_W(CW)) i_tile_pipe_seq (.*);

  int errs = 0, total = 0, cyc = 0;
  int dma_lat = 3, acc_lat = 3, dma_cnt = 0, acc_cnt = 0;
  logic [31:0] act_log [256];
  logic [31:0] exp_log [256];
  int n_act = 0, n_exp = 0, viol3 = 0, viol7 = 0;
  bit pro_pend = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // engine models: done level falls at the edge that samples start (R11)
  always @(posedge clk) begin
    if (dma_start) begin dma_done <= 0; dma_cnt <= dma_lat; end
    else if (dma_cnt > 1) dma_cnt <= dma_cnt - 1;
    else if (dma_cnt == 1) begin dma_cnt <= 0; dma_done <= 1; end
    if (acc_start) begin acc_done <= 0; acc_cnt <= acc_lat; end
    else if (acc_cnt > 1) acc_cnt <= acc_cnt - 1;
    else if (acc_cnt == 1) begin acc_cnt <= 0; acc_done <= 1; end
  end

  function automatic logic [31:0] ev(int t, int b, int r, int c, int d);
    return {4'(t), 4'(b), 8'(r / P), 8'(c / P), 8'(d / P)};
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (dma_start) begin
        if (!dma_done) viol7++;
        if (n_act < 256) act_log[n_act] = ev(1, int'(dma_bank), int'(dma_row), int'(dma_col), 0);
        n_act++;
      end
      if (wgt_load) begin
        if (pro_pend) viol3++;
        if (!acc_done) viol7++;
        if (n_act < 256) act_log[n_act] = ev(2, 0, 0, int'(wgt_col), int'(wgt_depth));
        n_act++;
      end
      if (acc_start) begin
        if (!acc_done) viol7++;
        if (n_act < 256) act_log[n_act] = ev(3, int'(acc_bank), int'(acc_row), int'(acc_col), int'(acc_depth));
        n_act++;
      end
      if (dma_start && dma_col == 0) pro_pend = 1;
      else if (dma_done) pro_pend = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++; total++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
    end
  end

  task automatic build_exp(input int m, input int n, input int k);
    n_exp = 0;
    for (int mi = 0; mi < m; mi += P)
      for (int ki = 0; ki < k; ki += P) begin
        int b = 0;
        exp_log[n_exp++] = ev(1, 0, mi, 0, 0);
        for (int ni = 0; ni < n; ni += P) begin
          if (ni + P < n) exp_log[n_exp++] = ev(1, 1 - b, mi, ni + P, 0);
          exp_log[n_exp++] = ev(2, 0, 0, ni, ki);
          exp_log[n_exp++] = ev(3, b, mi, ni, ki);
          b = 1 - b;
        end
      end
  endtask

  task automatic run_job(input int m, input int n, input int k, input int ld, input int la,
                         input bit poke);
    int stall_exp, bad;
    dma_lat = ld; acc_lat = la;
    build_exp(m, n, k);
    @(negedge clk);
    n_act = 0; viol3 = 0; viol7 = 0;
    start = 1; dim_m = DW'(m); dim_n = DW'(n); dim_k = DW'(k);
    @(negedge clk);
    start = 0; dim_m = 0; dim_n = 0; dim_k = 0;
    chk(busy == 1, "R1 busy after start", busy, 1);
    if (poke) begin
      repeat (15) @(negedge clk);
      start = 1; dim_m = 64; dim_n = 64; dim_k = 64;
      @(negedge clk);
      start = 0; dim_m = 0; dim_n = 0; dim_k = 0;
    end
    while (!done) @(negedge clk);
    chk(busy == 0, "R9 busy low with done", busy, 0);
    @(negedge clk);
    chk(done == 0, "R9 done single cycle", done, 0);
    chk(n_act == n_exp, "R1 R5 command count", n_act, n_exp);
    bad = 0;
    for (int i = 0; i < n_exp && i < n_act; i++)
      if (act_log[i] !== exp_log[i]) begin
        if (bad == 0)
          $display("FAIL R2 R4 R6 event %0d actual=%0d expected=%0d", i, act_log[i], exp_log[i]);
        bad++;
      end
    total++; if (bad != 0) errs++;
    chk(viol3 == 0, "R3 prologue gate", viol3, 0);
    chk(viol7 == 0, "R7 engine busy at issue", viol7, 0);
    stall_exp = (m / P) * (k / P) * (n / P - 1) * ((ld - la - 3 > 0) ? ld - la - 3 : 0);
    chk(stall_cycles == CW'(stall_exp), "R8 stall count", stall_cycles, stall_exp);
  endtask

  task automatic t_reset;
    chk(busy == 0 && done == 0, "R1 reset busy/done", {busy, done}, 0);
    chk(!dma_start && !wgt_load && !acc_start, "R1 reset strobes", {dma_start, wgt_load, acc_start}, 0);
    chk(stall_cycles == 0, "R8 reset stall", stall_cycles, 0);
  endtask

  task automatic t_zero;
    @(negedge clk);
    n_act = 0;
    start = 1; dim_m = 32; dim_n = 0; dim_k = 32;
    @(negedge clk);
    start = 0; dim_m = 0; dim_k = 0;
    chk(done == 1 && busy == 0, "R10 zero size done", {done, busy}, 2);
    repeat (5) @(negedge clk);
    chk(n_act == 0, "R10 zero size no commands", n_act, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    run_job(16, 16, 16, 3, 4, 0);   // R5 single tile, no overlap
    run_job(32, 64, 32, 10, 2, 0);  // R8 fetch-bound
    run_job(48, 32, 16, 2, 12, 0);  // compute-bound
    run_job(16, 48, 16, 6, 3, 0);   // R8 both ends meet
    run_job(16, 48, 16, 7, 3, 0);   // R8 one stall per overlapped tile
    run_job(32, 32, 16, 4, 4, 1);   // R1 start ignored while busy
    t_zero();
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule